// File: doc/BRIEF.md
# Three-Phase Complementary PWM Timer with Crest-Loaded Duty Buffers

This block produces three pairs of complementary PWM outputs from a single triangle counter. The counter counts up from zero to one step past a programmed crest value m, turns back down to zero, and repeats. The period is therefore 2m+2 clock cycles. Each phase has an active compare register. The positive output of a phase is high while the count is above that phase's compare value. The negative output is its complement. Both outputs use an active-high level.

While the counter runs, the crest register and the active compare registers are locked. Duty changes go through one shadow register per phase. Each shadow register has a select bit that decides whether it is loaded into the active register. The load happens at the crest step or at the trough step, depending on the latched mode. A one-cycle flag marks each crest step and each trough step. Software programs the block through a simple write port. A level input starts the counter, and dropping it stops the counter.

Top module: `cpwm_crest_timer`

## Requirements
- R1: With crest value m (1 to 2^CNT_W-2), the running count rises 0,1,...,m,m+1, then falls m,m-1,...,1,0, then rises again 1,2,..., which gives a period of 2m+2 cycles.
- R2: `crest_flag` is high for exactly one cycle per period. It is high in the cycle after the upward step from m to m+1. The downward step from m+1 to m never raises it.
- R3: `trough_flag` is high for exactly one cycle per period. It is high in the cycle after the downward step from 1 to 0.
- R4: In mode 2'b11, each phase whose select bit is 1 copies its shadow value into its active compare register on the upward step from m to m+1. No copy happens on the downward step. A shadow write made on that same step does not take part in the copy; its new value waits for the next crest.
- R5: In mode 2'b10, the copy happens on the downward step from 1 to 0 instead. In modes 2'b00 and 2'b01, no copy takes place.
- R6: A phase whose select bit is 0 never has its active register loaded from its shadow. Its shadow simply keeps the last written value, and a later select-bit write of 1 lets that value move across at the next copy event.
- R7: Write address map for P phases: 0 is the crest, 1..P are the active compares, P+1..2P are the shadows, and 2P+1 holds the select bits in wr_data[P-1:0]. While running, writes to the crest and to the active compares are ignored. Shadow and select writes are always taken.
- R8: The mode input is latched only while the counter is stopped. A latched mode of 2'b10 or 2'b11 can be entered only from 2'b00, or by repeating the same value. Any other request leaves the mode unchanged.
- R9: While running, `pwm_p[i]` equals (count > active compare i) and `pwm_n[i]` is its inverse.
- R10: After reset, all outputs are 0 and the mode is 2'b00. A rising `run` loads 0 and counts up. Dropping `run` freezes the count and forces all six PWM outputs and both flags to 0. The next start begins again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter runs while high |
| mode | input | 2 | Requested copy mode, latched only when stopped |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| pwm_p | output | PHASES | Positive phase outputs |
| pwm_n | output | PHASES | Negative (complement) phase outputs |
| crest_flag | output | 1 | One-cycle pulse after the upward crest step |
| trough_flag | output | 1 | One-cycle pulse after the downward step to 0 |

## Verification
The collision that matters is a shadow-register write landing on the same clock edge as the crest copy. The bench tracks the count in its own model and times a shadow write to hit exactly the cycle where the count equals m while rising. The outputs must then show the old shadow value for one full period and switch to the new value only at the following crest. The same timing is repeated against the trough copy in mode 2'b10. The cycle of the output switch is judged against a reference model built from the requirements.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_ALT    = 2'b01,
    MODE_TROUGH = 2'b10,
    MODE_CREST  = 2'b11
  } cpwm_mode_e;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] crest,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             crest_evt,
  output logic             trough_evt,
  output logic             crest_flag,
  output logic             trough_flag
);
  logic             up_q, up_d;
  logic [CNT_W-1:0] cnt_d;
  logic             counting;
  logic [CNT_W:0]   top;

  assign counting   = run_q & run;
  assign top        = {1'b0, crest} + {{CNT_W{1'b0}}, 1'b1};
  assign crest_evt  = counting & up_q & (cnt_q == crest);
  assign trough_evt = counting & ~up_q & (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (run && !run_q) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (counting) begin
      if (up_q) begin
        if ({1'b0, cnt_q} == top) begin
          cnt_d = crest;
          up_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      up_q        <= 1'b1;
      run_q       <= 1'b0;
      crest_flag  <= 1'b0;
      trough_flag <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      up_q        <= up_d;
      run_q       <= run;
      crest_flag  <= crest_evt;
      trough_flag <= trough_evt;
    end
  end

  // R1
  crest_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ({1'b0, cnt_q} == top)) |=> (!run_q || cnt_q == $past(crest)));
  // R2
  crest_flag_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crest_flag |-> (run_q && up_q && ({1'b0, cnt_q} == top)));
  // R3
  trough_flag_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trough_flag |-> (run_q && !up_q && cnt_q == '0));
  // R10
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_q) |=> (cnt_q == '0 && up_q));
endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PHASES = 3,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          running,
  input  logic [1:0]                    mode_in,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          crest_evt,
  input  logic                          trough_evt,
  output logic [CNT_W-1:0]              crest_q,
  output logic [PHASES-1:0][CNT_W-1:0]  cmp_q
);
  localparam int SEL_ADDR = 2 * PHASES + 1;

  cpwm_mode_e                    mode_q, mode_d;
  logic [PHASES-1:0][CNT_W-1:0]  shd_q, shd_d, cmp_d;
  logic [PHASES-1:0]             sel_q, sel_d;
  logic [CNT_W-1:0]              crest_d;
  logic                          xfer;
  logic                          mode_ok;

  assign xfer    = (mode_q == MODE_CREST  && crest_evt) ||
                   (mode_q == MODE_TROUGH && trough_evt);
  assign mode_ok = !mode_in[1] || (mode_q == MODE_PLAIN) || (mode_in == mode_q);

  always_comb begin
    crest_d = crest_q;
    cmp_d   = cmp_q;
    shd_d   = shd_q;
    sel_d   = sel_q;
    mode_d  = mode_q;
    for (int i = 0; i < PHASES; i++) begin
      if (xfer && sel_q[i]) cmp_d[i] = shd_q[i];
    end
    if (wr_en) begin
      if (wr_addr == '0 && !running) crest_d = wr_data;
      for (int i = 0; i < PHASES; i++) begin
        if (wr_addr == ADDR_W'(i + 1) && !running) cmp_d[i] = wr_data;
        if (wr_addr == ADDR_W'(PHASES + 1 + i))    shd_d[i] = wr_data;
      end
      if (wr_addr == ADDR_W'(SEL_ADDR)) sel_d = wr_data[PHASES-1:0];
    end
    if (!running && mode_ok) mode_d = cpwm_mode_e'(mode_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crest_q <= '0;
      cmp_q   <= '0;
      shd_q   <= '0;
      sel_q   <= '0;
      mode_q  <= MODE_PLAIN;
    end else begin
      crest_q <= crest_d;
      cmp_q   <= cmp_d;
      shd_q   <= shd_d;
      sel_q   <= sel_d;
      mode_q  <= mode_d;
    end
  end

  // R7
  crest_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(crest_q));
  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(mode_q));
  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !crest_evt && !trough_evt) |=> $stable(cmp_q));
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CNT_W = 16
) (
  input  logic             running,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             out_p,
  output logic             out_n
);
  logic above;

  assign above = cnt > cmp;
  assign out_p = running & above;
  assign out_n = running & ~above;
endmodule

// File: rtl/cpwm_crest_timer.sv
module cpwm_crest_timer #(
  parameter int CNT_W  = 16,
  parameter int PHASES = 3,
  parameter int ADDR_W = $clog2(2 * PHASES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [PHASES-1:0] pwm_p,
  output logic [PHASES-1:0] pwm_n,
  output logic              crest_flag,
  output logic              trough_flag
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_s;
  logic [CNT_W-1:0]             cnt;
  logic                         running;
  logic                         crest_evt, trough_evt;
  logic [CNT_W-1:0]             crest;
  logic [PHASES-1:0][CNT_W-1:0] cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .run(run), .crest(crest),
    .cnt_q(cnt), .run_q(running), .crest_evt(crest_evt), .trough_evt(trough_evt),
    .crest_flag(crest_flag), .trough_flag(trough_flag)
  );

  cpwm_regs #(.CNT_W(CNT_W), .PHASES(PHASES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .running(running), .mode_in(mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .crest_evt(crest_evt), .trough_evt(trough_evt),
    .crest_q(crest), .cmp_q(cmp)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    cpwm_phase #(.CNT_W(CNT_W)) u_ph (
      .running(running), .cnt(cnt), .cmp(cmp[g]),
      .out_p(pwm_p[g]), .out_n(pwm_n[g])
    );
  end
endmodule

// File: tb/tb_cpwm_crest_timer.sv
`timescale 1ns/1ps
module tb_cpwm_crest_timer;
  localparam int W = 16;
  localparam int P = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic run_i;
  logic [1:0] mode_i;
  logic wr_en_i;
  logic [AW-1:0] wr_addr_i;
  logic [W-1:0] wr_data_i;
  logic [P-1:0] pwm_p, pwm_n;
  logic crest_flag, trough_flag;

  always #2 clk = ~clk;

  cpwm_crest_timer #(.CNT_W(W), .PHASES(P)) dut (
    .clk(clk), .rst_n(rst_n), .run(run_i), .mode(mode_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .crest_flag(crest_flag), .trough_flag(trough_flag)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R10";

  // reference model state
  logic [W-1:0] m_cnt, m_crest;
  logic m_up, m_run, m_cf, m_tf;
  logic [P-1:0][W-1:0] m_cmp, m_shd;
  logic [P-1:0] m_sel;
  logic [1:0] m_mode;

  function automatic logic [2*P+1:0] expect_out();
    logic [P-1:0] ep, en;
    for (int i = 0; i < P; i++) begin
      ep[i] = m_run && (m_cnt > m_cmp[i]);
      en[i] = m_run && !(m_cnt > m_cmp[i]);
    end
    return {ep, en, m_cf, m_tf};
  endfunction

  task automatic mdl_step();
    logic counting, cf, tf, xf;
    logic [W:0] top;
    logic [W-1:0] ncnt;
    logic nup;
    logic [P-1:0][W-1:0] ncmp, nshd;
    logic [W-1:0] ncrest;
    logic [P-1:0] nsel;
    logic [1:0] nmode;
    counting = m_run && run_i;
    top = {1'b0, m_crest} + 1;
    cf = counting && m_up && (m_cnt == m_crest);
    tf = counting && !m_up && (m_cnt == 1);
    xf = (m_mode == 2'b11 && cf) || (m_mode == 2'b10 && tf);
    ncnt = m_cnt; nup = m_up;
    if (run_i && !m_run) begin ncnt = 0; nup = 1; end
    else if (counting) begin
      if (m_up) begin
        if ({1'b0, m_cnt} == top) begin ncnt = m_crest; nup = 0; end
        else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin ncnt = 1; nup = 1; end
        else ncnt = m_cnt - 1;
      end
    end
    ncmp = m_cmp; nshd = m_shd; ncrest = m_crest; nsel = m_sel; nmode = m_mode;
    for (int i = 0; i < P; i++) if (xf && m_sel[i]) ncmp[i] = m_shd[i];
    if (wr_en_i) begin
      if (wr_addr_i == 0 && !m_run) ncrest = wr_data_i;
      for (int i = 0; i < P; i++) begin
        if (int'(wr_addr_i) == i + 1 && !m_run) ncmp[i] = wr_data_i;
        if (int'(wr_addr_i) == P + 1 + i) nshd[i] = wr_data_i;
      end
      if (int'(wr_addr_i) == 2 * P + 1) nsel = wr_data_i[P-1:0];
    end
    if (!m_run && (!mode_i[1] || m_mode == 2'b00 || mode_i == m_mode)) nmode = mode_i;
    m_cnt = ncnt; m_up = nup; m_run = run_i; m_cf = cf; m_tf = tf;
    m_cmp = ncmp; m_shd = nshd; m_crest = ncrest; m_sel = nsel; m_mode = nmode;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: DUT and model advance on the same inputs, then outputs compared mid-cycle
  task automatic tick();
    @(posedge clk);
    mdl_step();
    @(negedge clk);
    check(cur_tag, 32'({pwm_p, pwm_n, crest_flag, trough_flag}), 32'(expect_out()));
    wr_en_i = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = W'(d);
    tick();
  endtask

  task automatic stop_run();
    run_i = 1'b0; tick();
  endtask

  task automatic wait_crest_step();
    // advance until the model will take the upward m -> m+1 step at the next edge
    while (!(m_run && m_up && m_cnt == m_crest)) tick();
  endtask

  task automatic wait_trough_step();
    while (!(m_run && !m_up && m_cnt == 1)) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ncf, ntf;
    void'($urandom(32'd20240611));
    m_cnt = 0; m_crest = 0; m_up = 1; m_run = 0; m_cf = 0; m_tf = 0;
    m_cmp = '0; m_shd = '0; m_sel = '0; m_mode = 2'b00;
    rst_n = 1'b0; run_i = 1'b0; mode_i = 2'b00; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 reset", 32'({pwm_p, pwm_n, crest_flag, trough_flag}), 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 / R9: sequence around the crest seen through compares m-1, m, m+1
    cur_tag = "R1";
    wr(0, 5); wr(1, 4); wr(2, 5); wr(3, 6);
    run_i = 1'b1;
    ncf = 0; ntf = 0;
    for (int k = 0; k < 49; k++) begin
      tick();
      ncf += int'(crest_flag);
      ntf += int'(trough_flag);
    end
    // R2: once per period; R3: once per period
    check("R2 crest pulses", 32'(ncf), 32'd4);
    check("R3 trough pulses", 32'(ntf), 32'd4);

    // R7: writes to crest and active compare ignored while running
    cur_tag = "R7";
    wr(0, 9); wr(1, 0); wr(3, 1);
    repeat (14) tick();

    // R10: stop freezes and clears outputs, restart from 0
    cur_tag = "R10";
    stop_run();
    repeat (3) tick();
    run_i = 1'b1; repeat (8) tick();
    stop_run();

    // R4: crest-buffered copy, shadow written mid-period
    cur_tag = "R4";
    mode_i = 2'b11; tick();
    wr(1, 1); wr(2, 2); wr(3, 3); wr(7, 7);
    run_i = 1'b1; repeat (9) tick();
    wr(4, 4); wr(5, 0); wr(6, 5);
    repeat (20) tick();
    // R4 collision: shadow write on the crest step itself
    cur_tag = "R4 collision";
    wait_crest_step();
    wr(4, 2);
    repeat (26) tick();

    // R8: 11 -> 10 without passing 00 is refused
    cur_tag = "R8";
    stop_run();
    mode_i = 2'b10; tick();
    wr(5, 3);
    run_i = 1'b1; repeat (26) tick();
    stop_run();
    mode_i = 2'b00; tick();
    mode_i = 2'b10; tick();

    // R5: trough copy in mode 10, with collision at the trough step
    cur_tag = "R5";
    run_i = 1'b1; repeat (5) tick();
    wr(4, 5); wr(6, 1);
    repeat (26) tick();
    wait_trough_step();
    wr(4, 0);
    repeat (26) tick();
    // R5: modes 00/01 never copy
    stop_run();
    mode_i = 2'b01; tick();
    run_i = 1'b1;
    wr(4, 3); wr(5, 4); wr(6, 2);
    repeat (26) tick();
    stop_run();

    // R6: select 0 blocks copy, later select 1 lets held value across
    cur_tag = "R6";
    mode_i = 2'b00; tick();
    mode_i = 2'b11; tick();
    wr(7, 0);
    run_i = 1'b1;
    wr(4, 6); wr(5, 1); wr(6, 4);
    repeat (26) tick();
    wr(7, 2);
    repeat (26) tick();
    wr(7, 7);
    repeat (14) tick();
    stop_run();

    // constrained random mix
    cur_tag = "R1/R2/R3/R4/R5/R6/R7/R8/R9 random";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(99));
      if (!m_run) begin
        if (r < 30) begin
          wr_en_i = 1'b1; wr_addr_i = AW'($urandom_range(3));
          wr_data_i = (wr_addr_i == 0) ? W'($urandom_range(1, 12)) : W'($urandom_range(14));
        end else if (r < 45) begin
          mode_i = 2'($urandom_range(3));
        end else if (r < 75) begin
          run_i = 1'b1;
        end
      end else begin
        if (r < 3) run_i = 1'b0;
        else if (r < 30) begin
          wr_en_i = 1'b1; wr_addr_i = AW'($urandom_range(7));
          wr_data_i = (wr_addr_i == 7) ? W'($urandom_range(7)) :
                      (wr_addr_i == 0) ? W'($urandom_range(1, 12)) : W'($urandom_range(14));
        end
      end
      tick();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule